// File: doc/BRIEF.md
# Key-Locked Watchdog Timer

This block is a watchdog timer placed on a simple register bus. The bus has a byte address, write data, a write strobe, a read strobe and read data. A down-counter runs on the system clock. Its reload value and its control bits can be changed only while a separate key register holds the unlock value `0x0000482E`. Once it is armed, the counter falls by one each clock. When it reaches zero it stops, and it can raise a reset request to the system reset controller, an interrupt, or both.

Software arms the watchdog in five steps: unlock, clear the control register, load the timeout in clock ticks, set count-enable together with reset-enable, then relock. To stop it, software unlocks, writes zero to the control register and relocks. Loading zero into the counter while counting and reset are both enabled produces a reset request on the next clock, which gives the system a quick restart path.

Expiry causes are kept in a status register. The flag that records a watchdog-driven reset lives on the power-on reset alone, so software can read it after the warm reset the block itself requested. The bus has no handshake and no back-pressure. Every access completes in the cycle its strobe is high, and read data is valid in that same cycle.

Top module: `lockwd_top`

## Requirements
- R1: After power-on reset, reads of the counter (0x14), control (0x18), key (0x1C) and status (0x20) registers all return 0, and `wd_rst_req` and `wd_irq` are low.
- R2: A write to the key register at 0x1C unlocks the block when the data is 0x0000482E and locks it for any other value. A read of 0x1C returns 1 in bit 0 while unlocked and 0 while locked.
- R3: While the block is locked, writes to the counter (0x14) and the control (0x18) registers leave both unchanged.
- R4: The control register holds three bits: bit 0 is reset-enable, bit 1 is interrupt-enable and bit 2 is count-enable. Higher bits are not stored and read as 0.
- R5: While count-enable is set, the counter read at 0x14 falls by exactly one per clock and holds at zero. While count-enable is clear, it holds its value.
- R6: When the counter is loaded with N and count-enable and reset-enable are then written together, `wd_rst_req` rises on the (N+1)th clock edge after that write. It stays high for RST_CYCLES cycles and is raised only once per expiry.
- R7: Writing 0 to the counter while count-enable and reset-enable are set raises `wd_rst_req` on the next clock edge.
- R8: An expiry with interrupt-enable set raises status bit 3 and `wd_irq`. Writing 1 to status bit 3 clears both, and this write works without the key. Writing status bit 4 has no effect.
- R9: Status bit 4 is set whenever the block raises a reset request. It survives `warm_rst_n` and is cleared only by `por_n`.
- R10: A warm reset returns the counter, the control register, the key state and status bit 3 to 0.
- R11: An expiry with neither reset-enable nor interrupt-enable set leaves the counter at zero, with no reset request, no interrupt and no status bit set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| por_n | input | 1 | Power-on reset, active low; clears everything |
| warm_rst_n | input | 1 | Warm reset, active low; clears all but the watchdog-reset flag and the pulse generator |
| bus_addr | input | ADDR_W | Byte address of the access |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the cycle `bus_rd` is high, 0 otherwise |
| wd_rst_req | output | 1 | Reset request pulse to the reset controller |
| wd_irq | output | 1 | Watchdog interrupt, level, mirrors status bit 3 |

## Verification
The bench sweeps every timeout from 0 to 24 and counts the cycles from the arming write to the first cycle of the reset request. A design that started counting one edge late, or skipped the zero state, would miss by one, and a design that fired on every cycle spent at zero would show a second pulse or an overlong one. After each expiry the bench applies a warm reset and then a power-on reset. A status flag on the wrong reset domain shows up either lost or stuck. The bench also goes after key handling: locked and wrong-key writes, a status clear done while locked, and the zero-load restart path that a design firing only on a decrement to zero would miss.

// File: rtl/lockwd_pkg.sv
package lockwd_pkg;
  localparam int DATA_W = 32;
  localparam logic [DATA_W-1:0] UNLOCK_KEY = 32'h0000_482E;

  // Byte offsets of the registers
  localparam int OFF_COUNT  = 'h14;
  localparam int OFF_CTRL   = 'h18;
  localparam int OFF_KEY    = 'h1C;
  localparam int OFF_STATUS = 'h20;

  // Status bit positions
  localparam int ST_PEND_BIT = 3;
  localparam int ST_WARM_BIT = 4;

  // Control register: bit2 count, bit1 irq, bit0 reset
  typedef struct packed {
    logic count;
    logic irq;
    logic rst;
  } wd_ctl_t;
endpackage

// File: rtl/lockwd_counter.sv
module lockwd_counter #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             count_en,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic [CNT_W-1:0] cnt,
  output logic             expire
);
  logic [CNT_W-1:0] cnt_q;
  logic             fired_q;
  logic             at_zero;

  assign at_zero = (cnt_q == '0);
  assign expire  = count_en && at_zero && !fired_q && !load;
  assign cnt     = cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      fired_q <= 1'b0;
    end else begin
      if (load) begin
        cnt_q <= load_val;
      end else if (count_en && !at_zero) begin
        cnt_q <= cnt_q - 1'b1;
      end
      if (load || !count_en) begin
        fired_q <= 1'b0;
      end else if (expire) begin
        fired_q <= 1'b1;
      end
    end
  end

  // R5
  countdown_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (count_en && !load && !at_zero) |=> (cnt_q == $past(cnt_q) - 1'b1));

  // R5
  zero_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && at_zero) |=> (cnt_q == '0));

  // R6
  single_expire_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (expire && !load) |=> !expire);
endmodule

// File: rtl/lockwd_rstgen.sv
module lockwd_rstgen #(
  parameter int RST_CYCLES = 4
) (
  input  logic clk,
  input  logic por_n,
  input  logic fire,
  output logic rst_req,
  output logic warm_flag
);
  localparam int PW = $clog2(RST_CYCLES + 1);

  logic warm_q;

  generate
    if (RST_CYCLES <= 1) begin : g_single
      logic req_q;
      always_ff @(posedge clk) begin
        if (!por_n) req_q <= 1'b0;
        else        req_q <= fire;
      end
      assign rst_req = req_q;
    end else begin : g_multi
      logic [PW-1:0] left_q;
      always_ff @(posedge clk) begin
        if (!por_n) begin
          left_q <= '0;
        end else if (fire) begin
          left_q <= PW'(RST_CYCLES);
        end else if (left_q != '0) begin
          left_q <= left_q - 1'b1;
        end
      end
      assign rst_req = (left_q != '0);
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!por_n)    warm_q <= 1'b0;
    else if (fire) warm_q <= 1'b1;
  end
  assign warm_flag = warm_q;

  // R9
  flag_with_req_chk: assert property (@(posedge clk) disable iff (!por_n)
    rst_req |-> warm_q);

  // R6
  req_start_chk: assert property (@(posedge clk) disable iff (!por_n)
    $rose(rst_req) |-> $past(fire));
endmodule

// File: rtl/lockwd_regs.sv
module lockwd_regs
  import lockwd_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int CNT_W  = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic [CNT_W-1:0]  cnt_val,
  input  logic              expire,
  input  logic              warm_flag,
  output wd_ctl_t           ctl,
  output logic              load,
  output logic [CNT_W-1:0]  load_val,
  output logic              pending
);
  localparam logic [ADDR_W-1:0] A_COUNT  = ADDR_W'(OFF_COUNT);
  localparam logic [ADDR_W-1:0] A_CTRL   = ADDR_W'(OFF_CTRL);
  localparam logic [ADDR_W-1:0] A_KEY    = ADDR_W'(OFF_KEY);
  localparam logic [ADDR_W-1:0] A_STATUS = ADDR_W'(OFF_STATUS);

  logic    unlocked_q;
  wd_ctl_t ctl_q;
  logic    pend_q;
  logic    wr_key, wr_ctrl, wr_stat;

  assign wr_key   = bus_wr && (bus_addr == A_KEY);
  assign wr_ctrl  = bus_wr && (bus_addr == A_CTRL) && unlocked_q;
  assign wr_stat  = bus_wr && (bus_addr == A_STATUS);
  assign load     = bus_wr && (bus_addr == A_COUNT) && unlocked_q;
  assign load_val = bus_wdata[CNT_W-1:0];
  assign ctl      = ctl_q;
  assign pending  = pend_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      unlocked_q <= 1'b0;
      ctl_q      <= '0;
      pend_q     <= 1'b0;
    end else begin
      if (wr_key) unlocked_q <= (bus_wdata == UNLOCK_KEY);
      if (wr_ctrl) ctl_q <= wd_ctl_t'(bus_wdata[2:0]);
      if (expire && ctl_q.irq) begin
        pend_q <= 1'b1;
      end else if (wr_stat && bus_wdata[ST_PEND_BIT]) begin
        pend_q <= 1'b0;
      end
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (bus_rd) begin
      unique case (bus_addr)
        A_COUNT:  bus_rdata = DATA_W'(cnt_val);
        A_CTRL:   bus_rdata = DATA_W'(ctl_q);
        A_KEY:    bus_rdata = DATA_W'(unlocked_q);
        A_STATUS: begin
          bus_rdata[ST_PEND_BIT] = pend_q;
          bus_rdata[ST_WARM_BIT] = warm_flag;
        end
        default:  bus_rdata = '0;
      endcase
    end
  end

  // R3
  locked_ctrl_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && (bus_addr == A_CTRL) && !unlocked_q) |=> $stable(ctl_q));

  // R2
  unlock_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_key && (bus_wdata == UNLOCK_KEY)) |=> unlocked_q);

  // R8
  pend_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pend_q) |-> $past(expire && ctl_q.irq));
endmodule

// File: rtl/lockwd_top.sv
module lockwd_top
  import lockwd_pkg::*;
#(
  parameter int ADDR_W     = 8,
  parameter int CNT_W      = 32,
  parameter int RST_CYCLES = 4
) (
  input  logic              clk,
  input  logic              por_n,
  input  logic              warm_rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              wd_rst_req,
  output logic              wd_irq
);
  logic             rst_n;
  wd_ctl_t          ctl;
  logic             load;
  logic [CNT_W-1:0] load_val;
  logic [CNT_W-1:0] cnt;
  logic             expire;
  logic             warm_flag;
  logic             pending;
  logic             fire;

  assign rst_n  = por_n & warm_rst_n;
  assign fire   = expire & ctl.rst;
  assign wd_irq = pending;

  lockwd_regs #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_regs (
    .clk(clk), .rst_n(rst_n),
    .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .cnt_val(cnt), .expire(expire), .warm_flag(warm_flag),
    .ctl(ctl), .load(load), .load_val(load_val), .pending(pending)
  );

  lockwd_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n),
    .count_en(ctl.count), .load(load), .load_val(load_val),
    .cnt(cnt), .expire(expire)
  );

  lockwd_rstgen #(.RST_CYCLES(RST_CYCLES)) u_rstgen (
    .clk(clk), .por_n(por_n), .fire(fire),
    .rst_req(wd_rst_req), .warm_flag(warm_flag)
  );
endmodule

// File: tb/lockwd_top_tb.sv
module lockwd_top_tb;
  localparam int RSTC = 4;
  localparam logic [7:0] A_CNT = 8'h14, A_CTL = 8'h18, A_KEY = 8'h1C, A_ST = 8'h20;
  localparam logic [31:0] KEYV = 32'h0000_482E;

  logic        clk = 1'b0;
  logic        por_n = 1'b0;
  logic        warm_rst_n = 1'b1;
  logic [7:0]  bus_addr = '0;
  logic        bus_wr = 1'b0;
  logic        bus_rd = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        wd_rst_req, wd_irq;

  int vectors = 0;
  int fails = 0;
  logic done = 1'b0;

  always #10 clk = ~clk;

  lockwd_top #(.ADDR_W(8), .CNT_W(32), .RST_CYCLES(RSTC)) u_dut (
    .clk(clk), .por_n(por_n), .warm_rst_n(warm_rst_n),
    .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .wd_rst_req(wd_rst_req), .wd_irq(wd_irq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(posedge clk); #1;
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_rd = 1'b1;
    #1 d = bus_rdata;
    bus_rd = 1'b0;
  endtask

  task automatic do_por();
    @(negedge clk); por_n = 1'b0;
    repeat (2) @(posedge clk);
    #1 por_n = 1'b1;
  endtask

  task automatic do_warm();
    @(negedge clk); warm_rst_n = 1'b0;
    repeat (2) @(posedge clk);
    #1 warm_rst_n = 1'b1;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired actual=%h expected=%h", 0, 1);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    do_por();

    // R1 reset state
    rd(A_CNT, v); chk("R1 count", v, 0);
    rd(A_CTL, v); chk("R1 ctrl", v, 0);
    rd(A_KEY, v); chk("R1 key", v, 0);
    rd(A_ST, v);  chk("R1 status", v, 0);
    chk("R1 rst_req", {31'b0, wd_rst_req}, 0);
    chk("R1 irq", {31'b0, wd_irq}, 0);

    // R2 key handling
    wr(A_KEY, KEYV);        rd(A_KEY, v); chk("R2 unlocked", v, 1);
    wr(A_KEY, 32'h482F);    rd(A_KEY, v); chk("R2 wrong key", v, 0);
    wr(A_KEY, KEYV);        wr(A_KEY, 0); rd(A_KEY, v); chk("R2 relock", v, 0);

    // R4 control encoding, upper bits dropped
    wr(A_KEY, KEYV);
    wr(A_CTL, 32'hFFFF_FFF2); rd(A_CTL, v); chk("R4 ctrl mask", v, 2);
    wr(A_CTL, 0);

    // R3 locked writes ignored
    wr(A_CNT, 32'h1234);
    wr(A_KEY, 0);
    wr(A_CNT, 32'h55);  rd(A_CNT, v); chk("R3 count locked", v, 32'h1234);
    wr(A_CTL, 4);       rd(A_CTL, v); chk("R3 ctrl locked", v, 0);
    repeat (5) @(posedge clk);
    rd(A_CNT, v); chk("R3 no counting", v, 32'h1234);
    wr(A_KEY, 32'h482F); wr(A_CTL, 4); rd(A_CTL, v); chk("R3 wrong key", v, 0);

    // R5 live countdown and hold
    wr(A_KEY, KEYV);
    wr(A_CNT, 100);
    wr(A_CTL, 4);
    repeat (10) @(posedge clk);
    rd(A_CNT, v); chk("R5 live count", v, 90);
    wr(A_CTL, 0);
    rd(A_CNT, v); chk("R5 stop value", v, 88);
    repeat (6) @(posedge clk);
    rd(A_CNT, v); chk("R5 held", v, 88);

    // R11 expiry with no events enabled
    wr(A_CNT, 2); wr(A_CTL, 4);
    repeat (10) @(posedge clk); #1;
    chk("R11 no rst", {31'b0, wd_rst_req}, 0);
    chk("R11 no irq", {31'b0, wd_irq}, 0);
    rd(A_CNT, v); chk("R11 zero", v, 0);
    rd(A_ST, v);  chk("R11 status", v, 0);

    // R6 R9 R10 sweep over timeouts
    for (int n = 0; n <= 24; n++) begin
      int k;
      int len;
      int extra;
      do_por();
      wr(A_KEY, KEYV); wr(A_CTL, 0); wr(A_CNT, n); wr(A_CTL, 5);
      k = 0;
      while (k < n + 8) begin
        @(posedge clk); #1; k++;
        if (wd_rst_req) break;
      end
      chk($sformatf("R6 delay n=%0d", n), k, n + 1);
      len = 0;
      while (wd_rst_req && len < RSTC + 8) begin
        len++; @(posedge clk); #1;
      end
      chk($sformatf("R6 width n=%0d", n), len, RSTC);
      extra = 0;
      for (int i = 0; i < 10; i++) begin
        @(posedge clk); #1;
        if (wd_rst_req) extra++;
      end
      chk($sformatf("R6 once n=%0d", n), extra, 0);
      chk("R6 no irq", {31'b0, wd_irq}, 0);
      rd(A_ST, v); chk("R9 flag set", v, 32'h10);
      do_warm();
      rd(A_ST, v);  chk("R9 survives warm", v, 32'h10);
      rd(A_CTL, v); chk("R10 ctrl cleared", v, 0);
      rd(A_KEY, v); chk("R10 key cleared", v, 0);
      do_por();
      rd(A_ST, v);  chk("R9 por clears", v, 0);
    end

    // R10 counter cleared by warm reset
    wr(A_KEY, KEYV); wr(A_CNT, 77);
    do_warm();
    rd(A_CNT, v); chk("R10 count cleared", v, 0);

    // R7 restart path
    do_por();
    wr(A_KEY, KEYV); wr(A_CNT, 1000); wr(A_CTL, 5);
    wr(A_CNT, 0);
    chk("R7 not yet", {31'b0, wd_rst_req}, 0);
    @(posedge clk); #1;
    chk("R7 next edge", {31'b0, wd_rst_req}, 1);
    repeat (RSTC + 2) @(posedge clk);

    // R8 interrupt and write-one-to-clear
    do_por();
    begin
      int k;
      logic sawrst;
      wr(A_KEY, KEYV); wr(A_CNT, 3); wr(A_CTL, 6);
      k = 0; sawrst = 1'b0;
      while (k < 12) begin
        @(posedge clk); #1; k++;
        if (wd_rst_req) sawrst = 1'b1;
        if (wd_irq) break;
      end
      chk("R8 irq delay", k, 4);
      chk("R8 no rst", {31'b0, sawrst}, 0);
    end
    rd(A_ST, v); chk("R8 pending", v, 32'h08);
    wr(A_KEY, 0);
    wr(A_ST, 32'h10); rd(A_ST, v); chk("R8 bit4 write no effect", v, 32'h08);
    wr(A_ST, 32'h08); rd(A_ST, v); chk("R8 cleared locked", v, 0);
    chk("R8 irq low", {31'b0, wd_irq}, 0);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule